// File: doc/BRIEF.md
# MDIO management-bus master

This block is a register-driven master for the two-wire PHY management bus. A host talks to it through four 32-bit registers on a single-cycle write port with a combinational read path. The block produces the management clock (MDC) and drives or listens on the data line (MDIO) to run Clause 22 read and write frames, and Clause 45 address, read and write frames. The data line is brought out as separate output, output-enable and input pins, so a tri-state pad outside the block joins them onto the shared wire.

Transactions start as side effects of register writes. Writing the data word sends a write frame. Writing the control word with its read bit set sends a read frame. With Clause 45 selected, writing the address word sends an address frame. A busy flag covers each frame. A read-error flag reports a PHY that did not pull the line low in the second turnaround bit.

Register map (byte offset on `addr`, decoded by `addr[3:2]`):
- 0x0 configuration/status: bit 0 busy (read-only), bit 1 read-error (read-only), bit 6 Clause 45 select, bits 15:8 half-period field `H`, bit 23 falling-edge sampling select.
- 0x4 control: bits 4:0 register address (Clause 22) or device address (Clause 45), bits 9:5 PHY address, bit 15 read start (always reads back 0).
- 0x8 data: bits 15:0.
- 0xC address: bits 15:0.

All other bits read 0.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read 0, MDC is low and MDIO is released (`mdio_oe`=0).
- R2: The configuration fields read back at the bit positions of the register map. While a frame runs, MDC toggles every `H`+1 clocks, so its period is 2*(`H`+1) clocks.
- R3: A write to the data word while idle sends one frame, most significant bit first, with MDIO driven for all 64 bits. The frame is 32 ones, ST=01, OP=01, the 5-bit PHY address, the 5-bit register address, turnaround 10, then the 16 data bits.
- R4: A control write with bit 15 set, made while idle, sends ST=01 OP=10 with the PHY and register addresses from that same write. MDIO is released from bit 46 (the first turnaround bit) to the end of the frame. Afterwards the data word bits 15:0 hold the 16 bits read, first-received bit as the most significant.
- R5: Read-error is set when the PHY leaves MDIO high in the second turnaround bit of a read frame. It is cleared when any frame starts.
- R6: With Clause 45 selected, a write to the address word sends ST=00 OP=00, the PHY and device addresses, turnaround 10 and the 16-bit address. With Clause 22 selected, the word is only stored and no frame starts.
- R7: With Clause 45 selected, read frames use ST=00 OP=11 and write frames use ST=00 OP=01.
- R8: Busy reads 1 from the cycle after a starting write until the frame ends. While idle, MDC stays low and MDIO is released.
- R9: MDIO output changes only after an MDC falling edge. Input is sampled at the MDC rising edge, or at the falling edge when bit 23 is set.
- R10: Any register write made while busy is ignored.
- R11: A control write with bit 15 clear only updates the address fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Frames are produced by each of the five launch paths: Clause 22 write and read, and Clause 45 address, read and write. Each frame is compared bit by bit, together with its output-enable pattern. This separates the ST and OP codes and shows where the line is released. Reads are run against a responding PHY model and a missing one, which separates a correct turnaround check from a stuck flag. A PHY that changes its output late, on the rising edge, is read in both sampling modes: rising-edge sampling gets the word shifted by one bit plus a read error, while falling-edge sampling recovers it. Writes to every register are made in the middle of a frame to show they are dropped. Writes that must not start a frame are shown to leave MDC still.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int FRAME_BITS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST   = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA2    = BW'(FRAME_BITS - 17);
  localparam logic [BW-1:0] RELEASE = BW'(FRAME_BITS - 18);

  logic        busy, rd_err, c45, neg, is_rd;
  logic [7:0]  div, cnt;
  logic [4:0]  dev, port;
  logic [15:0] dat, adr;
  logic [BW-1:0] bitn;
  logic [FRAME_BITS-1:0] frame;

  wire [1:0] sel    = addr[3:2];
  wire       idle_wr = wr_en & ~busy;
  wire       go_rd  = idle_wr & (sel == 2'd1) & wdata[15];
  wire       go_wr  = idle_wr & (sel == 2'd2);
  wire       go_ad  = idle_wr & (sel == 2'd3) & c45;
  wire       go     = go_rd | go_wr | go_ad;
  wire       tick   = busy & (cnt == div);
  wire       fall   = tick & mdc;
  wire       smp    = tick & (mdc == neg);

  wire [1:0]  f_st   = c45 ? 2'b00 : 2'b01;
  wire [1:0]  f_op   = go_rd ? (c45 ? 2'b11 : 2'b10) : (go_ad ? 2'b00 : 2'b01);
  wire [4:0]  f_port = go_rd ? wdata[9:5] : port;
  wire [4:0]  f_dev  = go_rd ? wdata[4:0] : dev;
  wire [1:0]  f_ta   = go_rd ? 2'b11 : 2'b10;
  wire [15:0] f_pay  = go_rd ? 16'hFFFF : wdata[15:0];

  assign mdio_o  = frame[FRAME_BITS-1];
  assign mdio_oe = busy & ~(is_rd & (bitn >= RELEASE));

  always_comb begin
    case (sel)
      2'd0:    rdata = {8'b0, neg, 7'b0, div, 1'b0, c45, 4'b0, rd_err, busy};
      2'd1:    rdata = {16'b0, 6'b0, port, dev};
      2'd2:    rdata = {16'b0, dat};
      default: rdata = {16'b0, adr};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; rd_err <= 1'b0; c45 <= 1'b0; neg <= 1'b0; is_rd <= 1'b0;
      div <= '0; cnt <= '0; dev <= '0; port <= '0; dat <= '0; adr <= '0;
      bitn <= '0; frame <= '0; mdc <= 1'b0;
    end else begin
      if (idle_wr) begin
        case (sel)
          2'd0: begin neg <= wdata[23]; div <= wdata[15:8]; c45 <= wdata[6]; end
          2'd1: begin port <= wdata[9:5]; dev <= wdata[4:0]; end
          2'd2: dat <= wdata[15:0];
          default: adr <= wdata[15:0];
        endcase
      end
      if (go) begin
        busy   <= 1'b1;
        is_rd  <= go_rd;
        rd_err <= 1'b0;
        cnt    <= '0;
        mdc    <= 1'b0;
        bitn   <= '0;
        frame  <= {{(FRAME_BITS-32){1'b1}}, f_st, f_op, f_port, f_dev, f_ta, f_pay};
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 8'd1;
        if (tick) mdc <= ~mdc;
        if (smp && is_rd) begin
          if (bitn == TA2) rd_err <= mdio_i;
          else if (bitn > TA2) dat <= {dat[14:0], mdio_i};
        end
        if (fall) begin
          frame <= frame << 1;
          bitn  <= bitn + 1'b1;
          if (bitn == LAST) busy <= 1'b0;
        end
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic        busy,
  input logic        rd_err,
  input logic        is_rd,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] dat
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_busy_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  p_out_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdc && $past(mdc)) |-> $stable(mdio_o));

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr[3:2] == 2'd2 && !is_rd) |=> $stable(dat));

  p_err_only_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> $past(is_rd));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy),
  .rd_err(rd_err), .is_rd(is_rd), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .dat(dat)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic mdc, mdio_o, mdio_oe;

  int errors = 0, checks = 0, cyc = 0, pc = 0;
  bit phy_on = 1'b1, phy_late = 1'b0, done = 1'b0;
  logic [15:0] resp = '0;
  logic [63:0] cap_o, cap_e;
  logic [127:0] exp_q[$];
  string tag_q[$];

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic phy_bit(input int i);
    if (!phy_on) return 1'b1;
    if (i == 47) return 1'b0;
    if (i >= 48 && i <= 63) return resp[63-i];
    return 1'b1;
  endfunction

  // expected item: {oe pattern, bit values}
  task automatic push(input string tag, input logic [1:0] st, input logic [1:0] op,
                      input logic [4:0] phy, input logic [4:0] dv, input bit rd, input logic [15:0] d);
    logic [63:0] b, e;
    b = {32'hFFFF_FFFF, st, op, phy, dv, rd ? 2'b11 : 2'b10, rd ? 16'h0 : d};
    e = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    exp_q.push_back({e, b});
    tag_q.push_back(tag);
  endtask

  always @(posedge mdc) begin
    cap_o[63-pc] = mdio_o;
    cap_e[63-pc] = mdio_oe;
    pc++;
    if (phy_late) mdio_i = phy_bit(pc - 1);
    if (pc == 64) begin
      pc = 0;
      if (exp_q.size() == 0) check(1'b0, "unexpected frame", cap_o, 64'h0);
      else begin
        logic [127:0] it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(cap_e == it[127:64], {tg, " oe"}, cap_e, it[127:64]);
        check((cap_o & it[127:64]) == (it[63:0] & it[127:64]), {tg, " bits"},
              cap_o & it[127:64], it[63:0] & it[127:64]);
      end
    end
  end

  always @(negedge mdc) if (!phy_late) mdio_i = phy_bit(pc);

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(4'h0, v);
      if (!v[0]) return;
    end
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    reg_rd(a, v);
    check(v == e, tag, 64'(v), 64'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_reg(4'h0, 32'h0, "R1 cfg");
    expect_reg(4'h4, 32'h0, "R1 ctl");
    expect_reg(4'h8, 32'h0, "R1 data");
    expect_reg(4'hC, 32'h0, "R1 addr");
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 0);

    // R2 configuration readback
    reg_wr(4'h0, 32'h0000_0300);
    expect_reg(4'h0, 32'h0000_0300, "R2 cfg readback");

    // R11 control write without read bit
    reg_wr(4'h4, 32'h0000_00B1);
    expect_reg(4'h4, 32'h0000_00B1, "R11 ctl fields");
    repeat (20) @(negedge clk);
    expect_reg(4'h0, 32'h0000_0300, "R11 no busy");
    check(pc == 0 && mdc == 1'b0, "R11 no mdc", 64'(pc), 0);
    reg_wr(4'h4, 32'h0000_80B1 & 32'h0000_7FFF);
    expect_reg(4'h4, 32'h0000_00B1, "R11 bit15 reads 0");

    // R3 Clause 22 write, R8 busy, R2 MDC period, R10 ignore
    push("R3 c22 write", 2'b01, 2'b01, 5'd5, 5'h11, 1'b0, 16'hBEEF);
    reg_wr(4'h8, 32'h0000_BEEF);
    expect_reg(4'h0, 32'h0000_0301, "R8 busy set");
    @(posedge mdc); d = cyc; @(posedge mdc); d = cyc - d;
    check(d == 8, "R2 mdc period", 64'(d), 64'd8);
    reg_wr(4'h8, 32'h0000_1111);
    reg_wr(4'h4, 32'h0000_8000);
    reg_wr(4'h0, 32'h0000_0000);
    reg_wr(4'hC, 32'h0000_2222);
    wait_idle();
    expect_reg(4'h8, 32'h0000_BEEF, "R10 data kept");
    expect_reg(4'h0, 32'h0000_0300, "R10 cfg kept");
    expect_reg(4'h4, 32'h0000_00B1, "R10 ctl kept");
    expect_reg(4'hC, 32'h0000_0000, "R10 addr kept");
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0 && pc == 0, "R10 single frame", 64'(exp_q.size()), 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle pins", {mdc, mdio_oe}, 0);

    // R4 Clause 22 read with responding PHY
    resp = 16'h1234;
    push("R4 c22 read", 2'b01, 2'b10, 5'd5, 5'h11, 1'b1, 16'h0);
    reg_wr(4'h4, 32'h0000_80B1);
    wait_idle();
    expect_reg(4'h8, 32'h0000_1234, "R4 read data");
    expect_reg(4'h0, 32'h0000_0300, "R5 no error");

    // R5 absent PHY
    phy_on = 1'b0;
    push("R5 c22 read absent", 2'b01, 2'b10, 5'd5, 5'h11, 1'b1, 16'h0);
    reg_wr(4'h4, 32'h0000_80B1);
    wait_idle();
    expect_reg(4'h0, 32'h0000_0302, "R5 error set");
    expect_reg(4'h8, 32'h0000_FFFF, "R4 floating data");
    phy_on = 1'b1;

    // R6 address write in Clause 22 mode
    reg_wr(4'hC, 32'h0000_00AA);
    repeat (20) @(negedge clk);
    expect_reg(4'h0, 32'h0000_0302, "R6 c22 addr no frame");
    check(pc == 0 && exp_q.size() == 0, "R6 no mdc", 64'(pc), 0);
    expect_reg(4'hC, 32'h0000_00AA, "R6 addr stored");

    // R6 Clause 45 address frame, falling-edge sampling, late PHY
    reg_wr(4'h0, 32'h0080_0340);
    phy_late = 1'b1; resp = 16'h0F0F;
    reg_wr(4'h4, 32'h0000_0067);
    push("R6 c45 address", 2'b00, 2'b00, 5'd3, 5'd7, 1'b0, 16'hA55A);
    reg_wr(4'hC, 32'h0000_A55A);
    wait_idle();
    expect_reg(4'h0, 32'h0080_0340, "R5 error cleared at start");

    // R7 Clause 45 read, R9 falling-edge sampling
    push("R7 c45 read", 2'b00, 2'b11, 5'd3, 5'd7, 1'b1, 16'h0);
    reg_wr(4'h4, 32'h0000_8067);
    wait_idle();
    expect_reg(4'h8, 32'h0000_0F0F, "R9 falling-edge sample");
    expect_reg(4'h0, 32'h0080_0340, "R9 no error falling");

    // R7 Clause 45 write
    push("R7 c45 write", 2'b00, 2'b01, 5'd3, 5'd7, 1'b0, 16'hC3C3);
    reg_wr(4'h8, 32'h0000_C3C3);
    wait_idle();
    expect_reg(4'h8, 32'h0000_C3C3, "R7 write data kept");

    // R9 rising-edge sampling with late PHY sees one-bit skew
    reg_wr(4'h0, 32'h0000_0300);
    push("R9 c22 read late", 2'b01, 2'b10, 5'd3, 5'd7, 1'b1, 16'h0);
    reg_wr(4'h4, 32'h0000_8067);
    wait_idle();
    expect_reg(4'h8, 32'h0000_0787, "R9 rising-edge sample");
    expect_reg(4'h0, 32'h0000_0302, "R9 rising error");
    phy_late = 1'b0;

    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R3 all frames seen", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule